// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Engine

This block pairs a bus master with one memory-backed slave. Both share a single set of lines that carry the address first and the data afterwards. A one-cycle address strobe qualifies the address phase. Separate write and read command lines mark the data phases, and a ready line from the slave marks valid read data. A local request port on the master starts one operation at a time:

- a single write
- a single read
- a read-modify-write under a mask
- a write followed by a read-back of the same word
- a block transfer of n consecutive words in either direction

Each operation, compound ones included, sends its address exactly once. The slave captures the address in the strobe cycle and decides whether the address falls in its window. It then accepts or returns data on the same lines. Reads take two cycles of fetch before the word appears, and the slave holds ready low during that time. A lock output marks compound and block operations as indivisible. One idle cycle always separates the two sides' driving, and a read that no slave answers ends with an error flag.

Top module: `mux_bus_engine`

## Requirements
- R1: After reset, `req_ready` is 1, `bus_lock` is 0 and neither `bus_m_drv` nor `bus_s_drv` is set.
- R2: Every accepted operation raises `bus_avalid` for exactly one cycle, with the operation's address on `bus_ad`. No data phase of that operation raises it again.
- R3: A single write of word D to a selected address, followed by a single read of that address, returns D. `bus_ready` first rises 3 cycles after the `bus_avalid` cycle.
- R4: The slave responds only to addresses whose bits [15:6] equal 0x010, which is the range 0x0400 to 0x043F. Bits [5:0] index the word. For an address outside this range:
  - the slave never drives the lines;
  - a read ends after 8 wait cycles with `rsp_err` = 1;
  - a write leaves every stored word unchanged.
- R5: In no cycle are `bus_m_drv` and `bus_s_drv` both 1. In the cycle after either driver switches off, the other is not on.
- R6: A read-modify-write (`req_op` = 2) returns the old word in `rsp_rdata` and stores (old & ~`req_mask`) | (`req_wdata` & `req_mask`).
- R7: A write-then-read (`req_op` = 3) stores `req_wdata` and returns the read-back word in `rsp_rdata`.
- R8: A block write (`req_op` = 4, `req_blk_wr` = 1, length n) pulses `wdata_pop` n times. Word i is stored at address A+i, where word i is the value of `blk_wdata` in the cycle of the i-th pop.
- R9: A block read (`req_op` = 4, `req_blk_wr` = 0, length n) produces n `beat_valid` pulses carrying the words at A, A+1, … in order.
- R10: `bus_lock` is high in every cycle from the address phase to the last data phase of a compound or block operation (op 2, 3, 4). It is low during single operations (op 0 write, op 1 read) and in the `rsp_done` cycle.
- R11: While `req_ready` is 0, `req_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start an operation (taken when req_ready is 1) |
| req_op | input | 3 | 0 write, 1 read, 2 read-modify-write, 3 write-then-read, 4 block |
| req_addr | input | 16 | Operation address |
| req_wdata | input | 16 | Write word, or merge value for op 2 |
| req_mask | input | 16 | Merge mask for op 2 |
| req_len | input | 8 | Block word count (0 treated as 1) |
| req_blk_wr | input | 1 | Block direction, 1 = write |
| blk_wdata | input | 16 | Current block write word |
| req_ready | output | 1 | Master idle and accepting |
| wdata_pop | output | 1 | blk_wdata consumed this cycle |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Read timed out (valid with rsp_done) |
| rsp_rdata | output | 16 | Last word read |
| beat_valid | output | 1 | A read word arrived |
| beat_data | output | 16 | That read word |
| bus_ad | output | 16 | Resolved shared address/data lines |
| bus_avalid | output | 1 | Address strobe |
| bus_ready | output | 1 | Slave read data valid |
| bus_lock | output | 1 | Compound operation in progress |
| bus_m_drv | output | 1 | Master drives the lines |
| bus_s_drv | output | 1 | Slave drives the lines |

## Verification
The bench targets the driver hand-offs:
- read into the write of a read-modify-write;
- write into the read-back;
- the end of a block read.

A missing idle cycle at any of these shows up as overlapping or back-to-back drivers. It checks that lock covers the exact phase count of each compound operation and drops in the completion cycle. A design that released lock early, or kept it through completion, fails those counts. Block transfers are checked for one address strobe and consecutive word placement, which catches an engine that re-sends the address or increments on single operations. An out-of-range read must time out with an error and an out-of-range write must not alias onto the low address bits. A request raised during a busy block must be dropped.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

  typedef enum logic [2:0] {
    OP_WR  = 3'd0,
    OP_RD  = 3'd1,
    OP_RMW = 3'd2,
    OP_WTR = 3'd3,
    OP_BLK = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_WDATA,
    S_RD,
    S_TURN,
    S_DONE
  } mst_state_e;

  // merged word of a masked update
  function automatic logic [15:0] rmw_merge(input logic [15:0] old_w,
                                            input logic [15:0] mask,
                                            input logic [15:0] val);
    return (old_w & ~mask) | (val & mask);
  endfunction

  function automatic logic is_compound(input op_e op);
    return (op == OP_RMW) || (op == OP_WTR) || (op == OP_BLK);
  endfunction

endpackage

// File: rtl/mbus_master.sv
module mbus_master
  import mbus_pkg::*;
#(
  parameter int DW  = 16,
  parameter int LW  = 8,
  parameter int TMO = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_mask,
  input  logic [LW-1:0] req_len,
  input  logic          req_blk_wr,
  input  logic [DW-1:0] blk_wdata,
  input  logic [DW-1:0] bus_in,
  input  logic          ready,
  output logic          req_ready,
  output logic          m_oe,
  output logic [DW-1:0] m_dout,
  output logic          avalid,
  output logic          cmd_wr,
  output logic          cmd_rd,
  output logic          seq,
  output logic          lock,
  output logic          wdata_pop,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          beat_valid,
  output logic [DW-1:0] beat_data
);
  localparam int TW = $clog2(TMO);

  mst_state_e    st;
  op_e           op_q;
  logic [DW-1:0] addr_q, wd_q, mask_q, rd_q;
  logic [LW-1:0] left_q;
  logic          blkwr_q, err_q;
  logic [TW-1:0] tmo_q;

  logic last_word, rd_hit, rd_giveup;
  assign last_word = (left_q == LW'(1));
  assign rd_hit    = (st == S_RD) && ready;
  assign rd_giveup = (st == S_RD) && !ready && (tmo_q == TW'(TMO - 1));

  assign req_ready = (st == S_IDLE);
  assign avalid    = (st == S_ADDR);
  assign cmd_wr    = (st == S_WDATA);
  assign cmd_rd    = (st == S_RD);
  assign m_oe      = (st == S_ADDR) || (st == S_WDATA);
  assign wdata_pop = (st == S_WDATA) && (op_q == OP_BLK);
  assign m_dout    = (st == S_ADDR) ? addr_q : (wdata_pop ? blk_wdata : wd_q);
  assign seq       = (op_q == OP_BLK) && (st != S_IDLE) && (st != S_DONE);
  assign lock      = is_compound(op_q) &&
                     ((st == S_ADDR) || (st == S_WDATA) || (st == S_RD) || (st == S_TURN));
  assign rsp_done  = (st == S_DONE);
  assign rsp_err   = err_q;
  assign rsp_rdata = rd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      op_q       <= OP_WR;
      addr_q     <= '0;
      wd_q       <= '0;
      mask_q     <= '0;
      rd_q       <= '0;
      left_q     <= '0;
      blkwr_q    <= 1'b0;
      err_q      <= 1'b0;
      tmo_q      <= '0;
      beat_valid <= 1'b0;
      beat_data  <= '0;
    end else begin
      beat_valid <= rd_hit;
      if (rd_hit) beat_data <= bus_in;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= op_e'(req_op);
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          mask_q  <= req_mask;
          left_q  <= (req_len == '0) ? LW'(1) : req_len;
          blkwr_q <= req_blk_wr;
          err_q   <= 1'b0;
          st      <= S_ADDR;
        end
        S_ADDR: begin
          tmo_q <= '0;
          case (op_q)
            OP_WR, OP_WTR: st <= S_WDATA;
            OP_RD, OP_RMW: st <= S_RD;
            OP_BLK:        st <= blkwr_q ? S_WDATA : S_RD;
            default:       st <= S_DONE;
          endcase
        end
        S_WDATA: begin
          if (op_q == OP_WTR) st <= S_RD;
          else if (op_q == OP_BLK && !last_word) left_q <= left_q - LW'(1);
          else st <= S_DONE;
        end
        S_RD: begin
          if (ready) begin
            rd_q  <= bus_in;
            tmo_q <= '0;
            if (op_q == OP_RMW) begin
              wd_q <= rmw_merge(bus_in, mask_q, wd_q);
              st   <= S_TURN;
            end else if (op_q == OP_BLK && !last_word) begin
              left_q <= left_q - LW'(1);
            end else begin
              st <= S_DONE;
            end
          end else if (rd_giveup) begin
            err_q <= 1'b1;
            st    <= S_DONE;
          end else begin
            tmo_q <= tmo_q + TW'(1);
          end
        end
        S_TURN:  st <= S_WDATA;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  avalid_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avalid |=> !avalid);

  // R10
  lock_free_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> !lock);

  // R4
  err_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_err) |-> $past(cmd_rd && !ready));

endmodule

// File: rtl/mbus_slave.sv
module mbus_slave #(
  parameter int          DW   = 16,
  parameter int          AW   = 6,
  parameter logic [15:0] BASE = 16'h0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_in,
  input  logic          avalid,
  input  logic          cmd_wr,
  input  logic          cmd_rd,
  input  logic          seq,
  output logic          s_oe,
  output logic [DW-1:0] s_dout,
  output logic          ready
);
  localparam int DEPTH = 1 << AW;

  function automatic logic in_window(input logic [DW-1:0] a);
    return a[DW-1:AW] == BASE[DW-1:AW];
  endfunction

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] a_q;
  logic          sel_q;
  logic [1:0]    phase;     // 0 idle, 1 fetch, 2 drive

  logic wr_en, rd_start, beat_end;
  assign wr_en    = cmd_wr && sel_q;
  assign rd_start = cmd_rd && sel_q && (phase == 2'd0);
  assign beat_end = (phase == 2'd2);

  assign s_oe   = beat_end;
  assign ready  = beat_end;
  assign s_dout = mem[a_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q   <= '0;
      sel_q <= 1'b0;
      phase <= 2'd0;
    end else if (avalid) begin
      a_q   <= bus_in[AW-1:0];
      sel_q <= in_window(bus_in);
      phase <= 2'd0;
    end else begin
      if (rd_start)               phase <= 2'd1;
      else if (phase == 2'd1)     phase <= 2'd2;
      else if (beat_end)          phase <= 2'd0;
      if ((wr_en || beat_end) && seq) a_q <= a_q + AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[a_q] <= bus_in;
  end

  // R4
  quiet_unsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_oe |-> sel_q);

  // R3
  read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> ($past(cmd_rd, 1) && $past(cmd_rd, 2)));

endmodule

// File: rtl/mux_bus_engine.sv
module mux_bus_engine #(
  parameter int          DW   = 16,
  parameter int          LW   = 8,
  parameter int          AW   = 6,
  parameter int          TMO  = 8,
  parameter logic [15:0] BASE = 16'h0400
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] req_mask,
  input  logic [LW-1:0] req_len,
  input  logic          req_blk_wr,
  input  logic [DW-1:0] blk_wdata,
  output logic          req_ready,
  output logic          wdata_pop,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata,
  output logic          beat_valid,
  output logic [DW-1:0] beat_data,
  output logic [DW-1:0] bus_ad,
  output logic          bus_avalid,
  output logic          bus_ready,
  output logic          bus_lock,
  output logic          bus_m_drv,
  output logic          bus_s_drv
);
  logic          m_oe, s_oe, avalid, cmd_wr, cmd_rd, seq, ready, lock;
  logic [DW-1:0] m_dout, s_dout, ad;

  // resolved shared lines; idle lines read as zero
  assign ad = m_oe ? m_dout : (s_oe ? s_dout : '0);

  mbus_master #(.DW(DW), .LW(LW), .TMO(TMO)) u_mst (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata, .req_mask,
    .req_len, .req_blk_wr, .blk_wdata,
    .bus_in(ad), .ready,
    .req_ready, .m_oe, .m_dout, .avalid, .cmd_wr, .cmd_rd, .seq, .lock,
    .wdata_pop, .rsp_done, .rsp_err, .rsp_rdata, .beat_valid, .beat_data
  );

  mbus_slave #(.DW(DW), .AW(AW), .BASE(BASE)) u_slv (
    .clk, .rst_n, .bus_in(ad), .avalid, .cmd_wr, .cmd_rd, .seq,
    .s_oe, .s_dout, .ready
  );

  assign bus_ad     = ad;
  assign bus_avalid = avalid;
  assign bus_ready  = ready;
  assign bus_lock   = lock;
  assign bus_m_drv  = m_oe;
  assign bus_s_drv  = s_oe;

  // R5
  single_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_oe && s_oe));

  // R5
  slave_to_master_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_oe) |-> !m_oe);

  // R5
  master_to_slave_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(m_oe) |-> !s_oe);

endmodule

// File: tb/mux_bus_engine_tb.sv
`timescale 1ns/1ps
module mux_bus_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_op = 3'd0;
  logic [15:0] req_addr = '0, req_wdata = '0, req_mask = '0;
  logic [7:0]  req_len = 8'd1;
  logic        req_blk_wr = 1'b0;
  logic [15:0] blk_wdata;
  logic        req_ready, wdata_pop, rsp_done, rsp_err, beat_valid;
  logic [15:0] rsp_rdata, beat_data, bus_ad;
  logic        bus_avalid, bus_ready, bus_lock, bus_m_drv, bus_s_drv;

  always #2 clk = ~clk;   // 250 MHz

  mux_bus_engine dut_i (
    .clk, .rst_n, .req_valid, .req_op, .req_addr, .req_wdata, .req_mask,
    .req_len, .req_blk_wr, .blk_wdata, .req_ready, .wdata_pop, .rsp_done,
    .rsp_err, .rsp_rdata, .beat_valid, .beat_data, .bus_ad, .bus_avalid,
    .bus_ready, .bus_lock, .bus_m_drv, .bus_s_drv
  );

  int nchk = 0, nerr = 0;

  // block write word source: advances on each pop
  logic [7:0] bk;
  always @(posedge clk) begin
    if (!rst_n) bk <= 8'd0;
    else if (wdata_pop) bk <= bk + 8'd1;
  end
  function automatic logic [15:0] pat(input logic [7:0] k);
    return 16'hA000 ^ {k, 8'h5C} ^ {8'h00, k};
  endfunction
  assign blk_wdata = pat(bk);

  // driver overlap / missing-gap monitor
  int conflicts = 0, gap_bad = 0;
  logic prev_m = 1'b0, prev_s = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_m_drv && bus_s_drv) conflicts++;
      if (prev_s && !bus_s_drv && bus_m_drv) gap_bad++;
      if (prev_m && !bus_m_drv && bus_s_drv) gap_bad++;
      prev_m = bus_m_drv;
      prev_s = bus_s_drv;
    end
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // results of the last operation
  logic [15:0] got_rdata, av_addr;
  logic        got_err, lock_at_done;
  int          lock_cyc, av_cnt, beat_n, lat, sdrv_cnt, pops;
  logic [15:0] beats [16];

  task automatic run_op(input logic [2:0] op, input logic [15:0] addr,
                        input logic [15:0] wd, input logic [15:0] mask,
                        input logic [7:0] len, input bit bwr, input bit inject);
    int cyc = 0, av_t = 0;
    bit seen_ready = 0;
    lock_cyc = 0; av_cnt = 0; beat_n = 0; lat = -1; sdrv_cnt = 0; pops = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_op = op; req_addr = addr; req_wdata = wd; req_mask = mask;
    req_len = len; req_blk_wr = bwr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int g = 0; g < 200; g++) begin
      if (inject && cyc == 2) begin
        req_op = 3'd0; req_addr = 16'h0406; req_wdata = 16'h0000; req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      if (bus_lock) lock_cyc++;
      if (bus_s_drv) sdrv_cnt++;
      if (wdata_pop) pops++;
      if (bus_avalid) begin av_cnt++; av_addr = bus_ad; av_t = cyc; end
      if (bus_ready && !seen_ready) begin seen_ready = 1; lat = cyc - av_t; end
      if (beat_valid && beat_n < 16) begin beats[beat_n] = beat_data; beat_n++; end
      if (rsp_done) begin
        got_rdata = rsp_rdata; got_err = rsp_err; lock_at_done = bus_lock;
        break;
      end
      cyc++;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic read_word(input logic [15:0] addr, output logic [15:0] d);
    run_op(3'd1, addr, 16'h0, 16'h0, 8'd1, 1'b0, 1'b0);
    d = got_rdata;
  endtask

  task automatic t_reset;
    check(req_ready === 1'b1, "R1 req_ready", {31'd0, req_ready}, 1);
    check(bus_lock === 1'b0, "R1 lock", {31'd0, bus_lock}, 0);
    check({bus_m_drv, bus_s_drv} === 2'b00, "R1 drivers", {30'd0, bus_m_drv, bus_s_drv}, 0);
  endtask

  task automatic t_single;
    logic [15:0] d;
    run_op(3'd0, 16'h0405, 16'hBEEF, 16'h0, 8'd1, 1'b0, 1'b0);
    check(av_cnt == 1, "R2 write strobe count", av_cnt, 1);
    check(av_addr == 16'h0405, "R2 write strobe addr", av_addr, 16'h0405);
    check(lock_cyc == 0, "R10 single write lock", lock_cyc, 0);
    read_word(16'h0405, d);
    check(d == 16'hBEEF, "R3 read back", d, 16'hBEEF);
    check(lat == 3, "R3 ready latency", lat, 3);
    check(got_err == 1'b0, "R3 no error", {31'd0, got_err}, 0);
    check(lock_cyc == 0, "R10 single read lock", lock_cyc, 0);
  endtask

  task automatic t_rmw;
    logic [15:0] d;
    run_op(3'd2, 16'h0405, 16'h1234, 16'h00FF, 8'd1, 1'b0, 1'b0);
    check(got_rdata == 16'hBEEF, "R6 old word", got_rdata, 16'hBEEF);
    check(av_cnt == 1, "R2 rmw strobe count", av_cnt, 1);
    check(lock_cyc == 6, "R10 rmw lock cycles", lock_cyc, 6);
    check(lock_at_done == 1'b0, "R10 rmw lock at done", {31'd0, lock_at_done}, 0);
    read_word(16'h0405, d);
    check(d == ((16'hBEEF & ~16'h00FF) | (16'h1234 & 16'h00FF)), "R6 merged word",
          d, 16'hBE34);
  endtask

  task automatic t_wtr;
    logic [15:0] d;
    run_op(3'd3, 16'h0410, 16'h5A5A, 16'h0, 8'd1, 1'b0, 1'b0);
    check(got_rdata == 16'h5A5A, "R7 read-back", got_rdata, 16'h5A5A);
    check(lock_cyc == 5, "R10 wtr lock cycles", lock_cyc, 5);
    read_word(16'h0410, d);
    check(d == 16'h5A5A, "R7 stored", d, 16'h5A5A);
  endtask

  task automatic t_block;
    logic [7:0]  base = bk;
    logic [15:0] d;
    run_op(3'd4, 16'h0420, 16'h0, 16'h0, 8'd4, 1'b1, 1'b0);
    check(pops == 4, "R8 pop count", pops, 4);
    check(av_cnt == 1, "R2 block strobe count", av_cnt, 1);
    check(lock_cyc == 5, "R10 block write lock cycles", lock_cyc, 5);
    read_word(16'h0422, d);
    check(d == pat(base + 8'd2), "R8 word at A+2", d, pat(base + 8'd2));
    run_op(3'd4, 16'h0420, 16'h0, 16'h0, 8'd4, 1'b0, 1'b0);
    check(beat_n == 4, "R9 beat count", beat_n, 4);
    for (int i = 0; i < 4; i++)
      check(beats[i] == pat(base + 8'(i)), "R9 beat order", beats[i], pat(base + 8'(i)));
    check(lock_cyc == 13, "R10 block read lock cycles", lock_cyc, 13);
  endtask

  task automatic t_unsel;
    logic [15:0] d;
    run_op(3'd1, 16'h2000, 16'h0, 16'h0, 8'd1, 1'b0, 1'b0);
    check(got_err == 1'b1, "R4 timeout error", {31'd0, got_err}, 1);
    check(sdrv_cnt == 0, "R4 slave silent", sdrv_cnt, 0);
    run_op(3'd0, 16'h2005, 16'h1111, 16'h0, 8'd1, 1'b0, 1'b0);
    read_word(16'h0405, d);
    check(d == 16'hBE34, "R4 write outside window ignored", d, 16'hBE34);
    check(got_err == 1'b0, "R4 in-window read no error", {31'd0, got_err}, 0);
  endtask

  task automatic t_busy;
    logic [15:0] d;
    run_op(3'd0, 16'h0406, 16'h7777, 16'h0, 8'd1, 1'b0, 1'b0);
    run_op(3'd4, 16'h0420, 16'h0, 16'h0, 8'd4, 1'b0, 1'b1);
    read_word(16'h0406, d);
    check(d == 16'h7777, "R11 request while busy dropped", d, 16'h7777);
  endtask

  initial begin
    #200000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_rmw();
    t_wtr();
    t_block();
    t_unsel();
    t_busy();
    check(conflicts == 0, "R5 driver overlap", conflicts, 0);
    check(gap_bad == 0, "R5 turnaround gap", gap_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule